// File: doc/BRIEF.md
# Block-Aligned Display Scan Address Counter

This block produces the sequential read address that display logic uses to fetch stored waveform points or readout characters from display memory. A processor write places an 8-bit value in the upper part of a 12-bit address. The same write clears the lower four bits, so every scan starts on a 16-word boundary. After the load, the counter steps forward by one on each accepted advance pulse.

Two single-cycle enable pulses can advance the counter, and a mode input chooses between them. In waveform mode the fixed refresh tick is used. In readout mode the character-fetch strobe from the readout sequencer is used. A master display enable blocks both sources. A carry flag marks the last word of each 16-word group. A running flag shows downstream gating that the scan is active.

A small control machine tracks the scan history. ST_IDLE is entered at reset and means no load has happened yet. An advance in ST_IDLE leaves it in ST_IDLE. Any load, from any state, moves it to ST_PRIMED. The first accepted advance in ST_PRIMED moves it to ST_RUN. ST_RUN stays in ST_RUN until the next load, which returns it to ST_PRIMED. Everything is synchronous to one clock with an active-low reset.

Top module: `disp_scan_counter`

## Requirements
- R1: After reset, scan_addr is 0, group_carry is 0 and scan_running is 0.
- R2: When load_n is low at a clock edge, scan_addr[11:4] takes load_data and scan_addr[3:0] becomes 0.
- R3: A load takes priority over an advance pulse in the same cycle.
- R4: group_carry is 1 exactly when scan_addr[3:0] equals 4'b1111.
- R5: With readout_sel at 0 (waveform mode), each refresh_tick pulse advances scan_addr by one, and char_strobe has no effect.
- R6: With readout_sel at 1 (readout mode), each char_strobe pulse advances scan_addr by one, and refresh_tick has no effect.
- R7: While disp_en is low, scan_addr does not advance in either mode.
- R8: An advance from 4095 wraps scan_addr to 0.
- R9: scan_running is 1 exactly when disp_en is high and the control machine is in ST_RUN. ST_RUN is reached only through an advance that follows a load. A load returns the machine to ST_PRIMED. An advance in ST_IDLE keeps it in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_n | input | 1 | Active-low load strobe |
| load_data | input | 8 | Upper address bits to load |
| readout_sel | input | 1 | 0: waveform mode, 1: readout mode |
| refresh_tick | input | 1 | Waveform refresh advance pulse |
| char_strobe | input | 1 | Readout character-fetch advance pulse |
| disp_en | input | 1 | Master display enable |
| scan_addr | output | 12 | Current scan address |
| group_carry | output | 1 | Last word of a 16-word group |
| scan_running | output | 1 | Scan active, for downstream gating |

## Verification
The bench loads all 256 upper values. After each load it steps sixteen times, alternating modes, so it passes every carry position. Loading 255 covers the wrap from 4095 to 0; a design without the wrap would leave that range. Each mode is driven with only the strobe that belongs to the other mode, and also with disp_en low, so a design that mixes up the sources or ignores the enable moves the address when it should not. Load is applied together with advances and swept across all input combinations. A design that gave the advance priority would end one word past the boundary, and a design with wrong state tracking would assert scan_running after reset or right after a load.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
    localparam int ADDR_W = 12;
    localparam int GRP_W  = 4;
    localparam int HI_W   = ADDR_W - GRP_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIMED = 2'd1,
        ST_RUN    = 2'd2
    } scan_state_t;
endpackage

// File: rtl/disp_scan_adv_sel.sv
module disp_scan_adv_sel (
    input  logic readout_sel,
    input  logic refresh_tick,
    input  logic char_strobe,
    input  logic disp_en,
    output logic advance
);
    logic picked;

    always_comb begin
        picked  = readout_sel ? char_strobe : refresh_tick;
        advance = disp_en & picked;
    end
endmodule

// File: rtl/disp_scan_addr_reg.sv
module disp_scan_addr_reg #(
    parameter int ADDR_W = 12,
    parameter int GRP_W  = 4,
    localparam int HI_W  = ADDR_W - GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_load,
    input  logic [HI_W-1:0]   load_hi,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              carry
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (do_load)
            addr_q <= {load_hi, {GRP_W{1'b0}}};
        else if (advance)
            addr_q <= addr_q + 1'b1;
    end

    always_comb begin
        addr  = addr_q;
        carry = &addr_q[GRP_W-1:0];
    end
endmodule

// File: rtl/disp_scan_fsm.sv
module disp_scan_fsm
    import disp_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic do_load,
    input  logic advance,
    input  logic disp_en,
    output logic running
);
    scan_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (do_load) st_d = ST_PRIMED;
            ST_PRIMED: if (do_load) st_d = ST_PRIMED;
                       else if (advance) st_d = ST_RUN;
            ST_RUN:    if (do_load) st_d = ST_PRIMED;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running = 1'b0;
        unique case (st_q)
            ST_IDLE:   running = 1'b0;
            ST_PRIMED: running = 1'b0;
            ST_RUN:    running = disp_en;
            default:   running = 1'b0;
        endcase
    end
endmodule

// File: rtl/disp_scan_counter.sv
module disp_scan_counter
    import disp_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [HI_W-1:0]   load_data,
    input  logic              readout_sel,
    input  logic              refresh_tick,
    input  logic              char_strobe,
    input  logic              disp_en,
    output logic [ADDR_W-1:0] scan_addr,
    output logic              group_carry,
    output logic              scan_running
);
    logic advance;
    logic do_load;

    assign do_load = ~load_n;

    disp_scan_adv_sel u_sel (
        .readout_sel (readout_sel),
        .refresh_tick(refresh_tick),
        .char_strobe (char_strobe),
        .disp_en     (disp_en),
        .advance     (advance)
    );

    disp_scan_addr_reg #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_load(do_load),
        .load_hi(load_data),
        .advance(advance),
        .addr   (scan_addr),
        .carry  (group_carry)
    );

    disp_scan_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_load(do_load),
        .advance(advance),
        .disp_en(disp_en),
        .running(scan_running)
    );
endmodule

// File: rtl/disp_scan_counter_chk.sv
module disp_scan_counter_chk
    import disp_scan_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic [HI_W-1:0]   load_data,
    input logic              readout_sel,
    input logic              refresh_tick,
    input logic              char_strobe,
    input logic              disp_en,
    input logic [ADDR_W-1:0] scan_addr,
    input logic              group_carry,
    input logic              scan_running
);
    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (scan_addr == {$past(load_data), {GRP_W{1'b0}}}));

    p_carry_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (group_carry && load_n && disp_en && (readout_sel ? char_strobe : refresh_tick))
        |=> (scan_addr[GRP_W-1:0] == '0));

    p_wave_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && disp_en && !readout_sel && refresh_tick)
        |=> (scan_addr == ADDR_W'($past(scan_addr) + 1'b1)));

    p_ro_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && disp_en && readout_sel && char_strobe)
        |=> (scan_addr == ADDR_W'($past(scan_addr) + 1'b1)));

    p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !disp_en) |=> $stable(scan_addr));

    p_run_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_running |-> disp_en);

    p_load_stops_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> !scan_running);
endmodule

bind disp_scan_counter disp_scan_counter_chk u_chk (.*);

// File: tb/disp_scan_counter_tb.sv
module disp_scan_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_n = 1'b1;
    logic [7:0]  load_data = '0;
    logic        readout_sel = 1'b0;
    logic        refresh_tick = 1'b0;
    logic        char_strobe = 1'b0;
    logic        disp_en = 1'b0;
    logic [11:0] scan_addr;
    logic        group_carry;
    logic        scan_running;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] m_addr = '0;
    int          m_st = 0;   // 0 idle, 1 primed, 2 run

    always #4 clk = ~clk;

    disp_scan_counter dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_data(load_data),
        .readout_sel(readout_sel), .refresh_tick(refresh_tick),
        .char_strobe(char_strobe), .disp_en(disp_en),
        .scan_addr(scan_addr), .group_carry(group_carry),
        .scan_running(scan_running)
    );

    task automatic check(input string tag);
        logic [13:0] act, exp;
        act = {scan_addr, group_carry, scan_running};
        exp = {m_addr, (m_addr[3:0] == 4'hF), (m_st == 2) && disp_en};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: addr/carry/run act=%h/%b/%b exp=%h/%b/%b", tag,
                     act[13:2], act[1], act[0], exp[13:2], exp[1], exp[0]);
        end
    endtask

    task automatic cyc(input string tag, input logic ld, input logic [7:0] d,
                       input logic m, input logic rt, input logic cs, input logic en);
        logic adv;
        @(negedge clk);
        load_n = ld; load_data = d; readout_sel = m;
        refresh_tick = rt; char_strobe = cs; disp_en = en;
        @(posedge clk);
        #1;
        adv = en && (m ? cs : rt);
        if (!ld) begin
            m_addr = {d, 4'h0};
            m_st = 1;
        end else if (adv) begin
            m_addr = m_addr + 12'd1;
            if (m_st == 1) m_st = 2;
        end
        check(tag);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: act=timeout exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // advance while never loaded: address moves, machine stays idle (R9)
        cyc("R9 idle advance", 1, 8'h00, 0, 1, 0, 1);
        cyc("R5 wave tick", 1, 8'h00, 0, 1, 0, 1);

        // full sweep of load values, 16 steps alternating modes (R2 R4 R5 R6 R8)
        for (int v = 0; v < 256; v++) begin
            cyc("R2 load", 0, 8'(v), 0, 0, 0, 1);
            for (int k = 0; k < 16; k++) begin
                if (k[0]) cyc("R6 readout step R4 R8", 1, 8'h00, 1, 0, 1, 1);
                else      cyc("R5 wave step R4 R8", 1, 8'h00, 0, 1, 0, 1);
            end
        end

        // wrong-source strobes ignored
        cyc("R2 load", 0, 8'h3C, 0, 0, 0, 1);
        cyc("R5 strobe ignored", 1, 8'h00, 0, 0, 1, 1);
        cyc("R6 tick ignored", 1, 8'h00, 1, 1, 0, 1);
        cyc("R9 run start", 1, 8'h00, 1, 0, 1, 1);
        // enable low blocks both sources, running drops
        cyc("R7 wave disabled", 1, 8'h00, 0, 1, 1, 0);
        cyc("R7 ro disabled", 1, 8'h00, 1, 1, 1, 0);
        cyc("R9 run resumes", 1, 8'h00, 1, 0, 0, 1);
        // load beats advance
        cyc("R3 load priority", 0, 8'hA5, 0, 1, 1, 1);
        cyc("R3 load priority ro", 0, 8'h5A, 1, 1, 1, 1);
        // wrap from 4095
        cyc("R2 load", 0, 8'hFF, 0, 0, 0, 1);
        for (int k = 0; k < 15; k++) cyc("R4 climb", 1, 8'h00, 0, 1, 0, 1);
        cyc("R8 wrap", 1, 8'h00, 0, 1, 0, 1);

        // all input combinations, repeated
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 32; c++) begin
                logic [4:0] b;
                b = 5'(c);
                cyc("R3 R5 R6 R7 combo", ~(b[4] & b[3]), 8'(c * 37 + r), b[0], b[1], b[2], b[3] | b[4]);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule